// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block decides, in every cycle, where a five-stage in-order pipeline takes the operands of the instruction now in execute, and the write data of a store now in the memory stage. It compares the two source register numbers of the execute-stage instruction with the single destination offered by each of the two younger pipeline registers: the one between execute and memory, and the one between memory and writeback. For each operand it returns a 2-bit select that drives the operand multiplexer in front of the ALU. A third, 1-bit select lets a value loaded by the instruction in writeback go straight into the write data of a store in the memory stage.

The block is purely combinational and has no state. Its inputs are the register-number and control fields already held in the pipeline registers, and its outputs go straight to multiplexer select lines. It does not stall anything. A use that comes right after a load still needs a bubble, and hazard logic elsewhere inserts it. A consumer three or more instructions behind its producer reads the register file, which writes in the first half of a cycle and reads in the second. Register 0 always reads as zero, so it is never a forwarding target.

Top module: `opfwd_unit`

## Requirements
- R1: When `mem_wr_en` is 1, `mem_dst` is not 0 and `mem_dst` equals `exe_src_a`, `sel_a` is 2'b10, which selects the execute-to-memory result.
- R2: When `mem_wr_en` is 1, `mem_dst` is not 0 and `mem_dst` equals `exe_src_b`, `sel_b` is 2'b10.
- R3: An operand's select is 2'b01, which selects the writeback value, when `wb_wr_en` is 1, `wb_dst` is not 0, `wb_dst` equals that operand's source, and the R1/R2 condition for that operand does not hold. This includes the case where `mem_dst` matches but `mem_wr_en` is 0.
- R4: When both stages write the same register and it matches an operand, the younger producer (execute-to-memory) wins and the select is 2'b10.
- R5: A source or store-data register number of 0 never forwards. The selects stay 2'b00 and `sel_store` stays 0, even when a stage claims to write register 0.
- R6: With no qualifying match, a select is 2'b00 (register file). This covers a write enable that is low and a producer that has already retired. The value 2'b11 is never produced.
- R7: `sel_store` is 1 exactly when `mem_is_store` is 1, `wb_is_load` is 1, `wb_wr_en` is 1, `wb_dst` is not 0 and `wb_dst` equals `mem_store_src`. Otherwise it is 0.
- R8: A writeback instruction that is not a load never sets `sel_store`, even when its destination matches the store's data register.
- R9: The outputs follow the inputs within the same cycle, with no clock and no retained state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exe_src_a | input | REG_W | First ALU source register number of the execute-stage instruction |
| exe_src_b | input | REG_W | Second ALU source register number of the execute-stage instruction |
| mem_dst | input | REG_W | Destination register of the instruction in the memory stage |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_W | Destination register of the instruction in writeback |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_is_load | input | 1 | Writeback-stage instruction is a load |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_store_src | input | REG_W | Register supplying the store's write data |
| sel_a | output | 2 | First operand select: 00 register file, 01 writeback, 10 memory stage |
| sel_b | output | 2 | Second operand select, same encoding |
| sel_store | output | 1 | 1 routes the loaded writeback value into the store data |

## Verification
Whenever the inputs are known, the bound checker tests the priority of the execute-to-memory match, the writeback fallback, the exclusion of register 0, the absence of the 2'b11 code and the exact conditions for the store path. Whether the selects settle within one cycle without a clock edge, and whether typical instruction sequences produce the intended selects, can only be shown by the bench's scenarios. These include a register written twice in a row followed by a reader, a load feeding a store, and a sweep over every register number.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  typedef enum logic [1:0] {
    FWD_REGFILE = 2'b00,
    FWD_WB      = 2'b01,
    FWD_MEM     = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPS = 2;
endpackage

// File: rtl/opfwd_dst_match.sv
module opfwd_dst_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wr_en,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  always_comb begin
    hit = wr_en && (dst != ZERO_REG) && (dst == src);
  end
endmodule

// File: rtl/opfwd_operand_sel.sv
module opfwd_operand_sel
  import opfwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  output fwd_sel_e         sel
);
  logic mem_hit;
  logic wb_hit;

  opfwd_dst_match #(.REG_W(REG_W)) i_mem_match (
    .src   (src),
    .dst   (mem_dst),
    .wr_en (mem_wr_en),
    .hit   (mem_hit)
  );

  opfwd_dst_match #(.REG_W(REG_W)) i_wb_match (
    .src   (src),
    .dst   (wb_dst),
    .wr_en (wb_wr_en),
    .hit   (wb_hit)
  );

  // Younger producer has priority over older one.
  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_REGFILE;
  end
endmodule

// File: rtl/opfwd_store_sel.sv
module opfwd_store_sel #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] store_src,
  input  logic             is_store,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  input  logic             wb_is_load,
  output logic             sel
);
  logic load_hit;

  opfwd_dst_match #(.REG_W(REG_W)) i_load_match (
    .src   (store_src),
    .dst   (wb_dst),
    .wr_en (wb_wr_en && wb_is_load),
    .hit   (load_hit)
  );

  always_comb begin
    sel = is_store && load_hit;
  end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] exe_src_a,
  input  logic [REG_W-1:0] exe_src_b,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  input  logic             wb_is_load,
  input  logic             mem_is_store,
  input  logic [REG_W-1:0] mem_store_src,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             sel_store
);
  logic [NUM_OPS-1:0][REG_W-1:0] op_src;
  fwd_sel_e                      op_sel [NUM_OPS];

  assign op_src[0] = exe_src_a;
  assign op_src[1] = exe_src_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    opfwd_operand_sel #(.REG_W(REG_W)) i_op_sel (
      .src       (op_src[g]),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .wb_dst    (wb_dst),
      .wb_wr_en  (wb_wr_en),
      .sel       (op_sel[g])
    );
  end

  assign sel_a = op_sel[0];
  assign sel_b = op_sel[1];

  opfwd_store_sel #(.REG_W(REG_W)) i_store_sel (
    .store_src  (mem_store_src),
    .is_store   (mem_is_store),
    .wb_dst     (wb_dst),
    .wb_wr_en   (wb_wr_en),
    .wb_is_load (wb_is_load),
    .sel        (sel_store)
  );
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] exe_src_a,
  input logic [REG_W-1:0] exe_src_b,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wr_en,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_wr_en,
  input logic             wb_is_load,
  input logic             mem_is_store,
  input logic [REG_W-1:0] mem_store_src,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic             sel_store
);
  logic known;

  always_comb begin
    known = !$isunknown({exe_src_a, exe_src_b, mem_dst, mem_wr_en, wb_dst,
                         wb_wr_en, wb_is_load, mem_is_store, mem_store_src,
                         sel_a, sel_b, sel_store});
    if (known) begin
      // R1 and R4: memory-stage producer wins for operand A
      if (mem_wr_en && mem_dst != '0 && mem_dst == exe_src_a)
        a_r1_mem_fwd_a: assert (sel_a == 2'b10);
      // R2: same rule for operand B
      if (mem_wr_en && mem_dst != '0 && mem_dst == exe_src_b)
        a_r2_mem_fwd_b: assert (sel_b == 2'b10);
      // R3: writeback used only when memory stage does not supply
      if (wb_wr_en && wb_dst != '0 && wb_dst == exe_src_a &&
          !(mem_wr_en && mem_dst == exe_src_a))
        a_r3_wb_fwd_a: assert (sel_a == 2'b01);
      if (wb_wr_en && wb_dst != '0 && wb_dst == exe_src_b &&
          !(mem_wr_en && mem_dst == exe_src_b))
        a_r3_wb_fwd_b: assert (sel_b == 2'b01);
      // R5: register zero never forwards
      if (exe_src_a == '0) a_r5_zero_a: assert (sel_a == 2'b00);
      if (exe_src_b == '0) a_r5_zero_b: assert (sel_b == 2'b00);
      if (mem_store_src == '0) a_r5_zero_st: assert (!sel_store);
      // R6: unused code never appears
      a_r6_no_code3: assert (sel_a != 2'b11 && sel_b != 2'b11);
      // R7 and R8: store path only for a qualifying load
      if (sel_store)
        a_r7_store_cond: assert (mem_is_store && wb_is_load && wb_wr_en &&
                                 wb_dst == mem_store_src);
      if (!wb_is_load) a_r8_not_load: assert (!sel_store);
    end
  end
endmodule

bind opfwd_unit opfwd_unit_chk #(.REG_W(REG_W)) i_opfwd_chk (
  .exe_src_a     (exe_src_a),
  .exe_src_b     (exe_src_b),
  .mem_dst       (mem_dst),
  .mem_wr_en     (mem_wr_en),
  .wb_dst        (wb_dst),
  .wb_wr_en      (wb_wr_en),
  .wb_is_load    (wb_is_load),
  .mem_is_store  (mem_is_store),
  .mem_store_src (mem_store_src),
  .sel_a         (sel_a),
  .sel_b         (sel_b),
  .sel_store     (sel_store)
);

// File: tb/test_opfwd_unit.sv
`timescale 1ns/1ps
module test_opfwd_unit;
  localparam int REG_W = 5;

  typedef struct packed {
    logic [3:0]       req;
    logic [REG_W-1:0] a;
    logic [REG_W-1:0] b;
    logic [REG_W-1:0] md;
    logic             mwe;
    logic [REG_W-1:0] wd;
    logic             wwe;
    logic             ld;
    logic             st;
    logic [REG_W-1:0] ss;
    logic [1:0]       ea;
    logic [1:0]       eb;
    logic             ec;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 5'd2,  5'd5,  5'd2,  1'b1, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0, 2'b10, 2'b00, 1'b0}, // R1
    '{4'd2, 5'd6,  5'd2,  5'd2,  1'b1, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0, 2'b00, 2'b10, 1'b0}, // R2
    '{4'd3, 5'd6,  5'd2,  5'd12, 1'b1, 5'd2,  1'b1, 1'b0, 1'b0, 5'd0, 2'b00, 2'b01, 1'b0}, // R3
    '{4'd3, 5'd2,  5'd9,  5'd3,  1'b1, 5'd2,  1'b1, 1'b0, 1'b0, 5'd0, 2'b01, 2'b00, 1'b0}, // R3
    '{4'd4, 5'd1,  5'd4,  5'd1,  1'b1, 5'd1,  1'b1, 1'b0, 1'b0, 5'd0, 2'b10, 2'b00, 1'b0}, // R4
    '{4'd4, 5'd7,  5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 1'b0, 1'b0, 5'd0, 2'b10, 2'b10, 1'b0}, // R4
    '{4'd3, 5'd3,  5'd3,  5'd3,  1'b0, 5'd3,  1'b1, 1'b0, 1'b0, 5'd0, 2'b01, 2'b01, 1'b0}, // R3
    '{4'd5, 5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 1'b1, 1'b1, 5'd0, 2'b00, 2'b00, 1'b0}, // R5
    '{4'd6, 5'd4,  5'd5,  5'd4,  1'b0, 5'd5,  1'b0, 1'b0, 1'b0, 5'd0, 2'b00, 2'b00, 1'b0}, // R6
    '{4'd6, 5'd8,  5'd9,  5'd10, 1'b1, 5'd11, 1'b1, 1'b0, 1'b0, 5'd0, 2'b00, 2'b00, 1'b0}, // R6
    '{4'd7, 5'd4,  5'd5,  5'd0,  1'b0, 5'd1,  1'b1, 1'b1, 1'b1, 5'd1, 2'b00, 2'b00, 1'b1}, // R7
    '{4'd8, 5'd4,  5'd5,  5'd0,  1'b0, 5'd1,  1'b1, 1'b0, 1'b1, 5'd1, 2'b00, 2'b00, 1'b0}, // R8
    '{4'd7, 5'd4,  5'd5,  5'd0,  1'b0, 5'd1,  1'b1, 1'b1, 1'b0, 5'd1, 2'b00, 2'b00, 1'b0}, // R7
    '{4'd7, 5'd4,  5'd5,  5'd0,  1'b0, 5'd1,  1'b0, 1'b1, 1'b1, 5'd1, 2'b00, 2'b00, 1'b0}, // R7
    '{4'd7, 5'd4,  5'd5,  5'd0,  1'b0, 5'd1,  1'b1, 1'b1, 1'b1, 5'd2, 2'b00, 2'b00, 1'b0}, // R7
    '{4'd4, 5'd2,  5'd2,  5'd2,  1'b1, 5'd2,  1'b1, 1'b1, 1'b1, 5'd2, 2'b10, 2'b10, 1'b1}  // R4
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [REG_W-1:0] exe_src_a, exe_src_b, mem_dst, wb_dst, mem_store_src;
  logic mem_wr_en, wb_wr_en, wb_is_load, mem_is_store;
  logic [1:0] sel_a, sel_b;
  logic sel_store;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  opfwd_unit #(.REG_W(REG_W)) i_opfwd_unit (
    .exe_src_a     (exe_src_a),
    .exe_src_b     (exe_src_b),
    .mem_dst       (mem_dst),
    .mem_wr_en     (mem_wr_en),
    .wb_dst        (wb_dst),
    .wb_wr_en      (wb_wr_en),
    .wb_is_load    (wb_is_load),
    .mem_is_store  (mem_is_store),
    .mem_store_src (mem_store_src),
    .sel_a         (sel_a),
    .sel_b         (sel_b),
    .sel_store     (sel_store)
  );

  task automatic drive(input vec_t v);
    exe_src_a = v.a;   exe_src_b = v.b;
    mem_dst   = v.md;  mem_wr_en = v.mwe;
    wb_dst    = v.wd;  wb_wr_en  = v.wwe;
    wb_is_load = v.ld; mem_is_store = v.st;
    mem_store_src = v.ss;
  endtask

  task automatic check(input string tag, input logic [1:0] ea,
                       input logic [1:0] eb, input logic ec);
    checks++;
    if (sel_a !== ea || sel_b !== eb || sel_store !== ec) begin
      failures++;
      $display("FAIL %s: got a=%b b=%b st=%b expected a=%b b=%b st=%b",
               tag, sel_a, sel_b, sel_store, ea, eb, ec);
    end
  endtask

  function automatic vec_t mk(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                              input logic [REG_W-1:0] md, input logic mwe,
                              input logic [REG_W-1:0] wd, input logic wwe);
    vec_t v = '0;
    v.a = a; v.b = b; v.md = md; v.mwe = mwe; v.wd = wd; v.wwe = wwe;
    return v;
  endfunction

  initial begin
    drive('0);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 reset idle", 2'b00, 2'b00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(posedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            VECS[i].ea, VECS[i].eb, VECS[i].ec);
    end

    // R4: two writes to r9 in a row, then a reader of r9 on both operands
    @(negedge clk);
    drive(mk(5'd9, 5'd9, 5'd9, 1'b1, 5'd9, 1'b1));
    @(posedge clk);
    check("R4 double write then read", 2'b10, 2'b10, 1'b0);

    // R6: producer three behind has retired, nothing matches
    @(negedge clk);
    drive(mk(5'd9, 5'd3, 5'd14, 1'b1, 5'd15, 1'b1));
    @(posedge clk);
    check("R6 retired producer", 2'b00, 2'b00, 1'b0);

    // R9: change inputs between edges, output follows without a clock edge
    @(negedge clk);
    drive(mk(5'd20, 5'd21, 5'd20, 1'b1, 5'd21, 1'b1));
    #1;
    check("R9 same-cycle A", 2'b10, 2'b01, 1'b0);
    drive(mk(5'd20, 5'd21, 5'd21, 1'b1, 5'd20, 1'b1));
    #1;
    check("R9 same-cycle B", 2'b01, 2'b10, 1'b0);

    // R1 and R2 sweep, R5 at register zero
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      drive(mk(r[REG_W-1:0], r[REG_W-1:0], r[REG_W-1:0], 1'b1, 5'd0, 1'b0));
      @(posedge clk);
      if (r == 0) check("R5 sweep zero", 2'b00, 2'b00, 1'b0);
      else        check($sformatf("R1 R2 sweep reg %0d", r), 2'b10, 2'b10, 1'b0);
    end

    // R3 sweep through the writeback path
    for (int r = 1; r < 32; r++) begin
      @(negedge clk);
      drive(mk(r[REG_W-1:0], 5'd0, 5'd0, 1'b1, r[REG_W-1:0], 1'b1));
      @(posedge clk);
      check($sformatf("R3 sweep reg %0d", r), 2'b01, 2'b00, 1'b0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule